// File: doc/BRIEF.md
# Second-Order Velocity Loop Filter

This block is the loop filter of a velocity-locked carrier tracking loop. At the end of every coherent integration interval a discriminator supplies one signed velocity error together with an update strobe. The filter runs that error through two cascaded, saturating integrators. It then presents three registered results: a jerk estimate, an acceleration estimate and a filtered velocity. The jerk estimate is the value fed into the first integrator. The acceleration estimate is the value fed into the second integrator. The velocity is the state of the second integrator. A downstream oscillator can use all three to build a phase ramp that follows higher-order dynamics between loop updates.

Two coefficient inputs configure the loop. The jerk coefficient carries the squared characteristic angular frequency multiplied by the update interval. The acceleration coefficient carries the loop gain multiplied by the characteristic angular frequency. Both are signed fixed-point values with `FRAC_W` fractional bits. Each product is scaled by an arithmetic right shift of `FRAC_W` bits, which rounds toward minus infinity. The outputs change only on an update and hold their value otherwise, so the filter runs at the loop update rate even though it is clocked by the system clock.

Top module: `vel_loop_filter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `jerk_o`, `accel_o` and `vel_o` read 0 and `valid_o` reads 0. Both integrator states are zero when the next update arrives.
- R2: On an update, `jerk_o` becomes floor(`err_i` * `kj_i` / 2^FRAC_W), saturated to the STATE_W-bit signed range.
- R3: On an update, `accel_o` becomes sat(S1 + floor(`err_i` * `ka_i` / 2^FRAC_W)). S1 is the first integrator's state from before this update.
- R4: On every update, the first integrator state becomes sat(S1 + jerk term). The effect appears in `accel_o` at the following update.
- R5: On an update, `vel_o` becomes sat(S2 + new acceleration term). S2 is the second integrator's state, which always equals the previous `vel_o`.
- R6: `valid_o` is high in exactly the cycle that follows each clock edge at which `upd_i` was sampled high. Back-to-back strobes give back-to-back valid cycles.
- R7: When `upd_i` is low, changes on `err_i`, `kj_i` and `ka_i` do not affect the outputs, which hold their last values.
- R8: The saturation bounds are +(2^(STATE_W-1) - 1) and -2^(STATE_W-1). With the default STATE_W of 24 these are 8388607 and -8388608. An integrator that reaches a bound stays there while its input keeps pushing the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_i | input | 1 | Loop update strobe, one cycle per update |
| err_i | input | ERR_W | Signed velocity discriminator error |
| kj_i | input | COEF_W | Signed jerk coefficient (w0^2 * T), FRAC_W fraction bits |
| ka_i | input | COEF_W | Signed acceleration coefficient (gain * w0), FRAC_W fraction bits |
| jerk_o | output | STATE_W | Filtered jerk estimate |
| accel_o | output | STATE_W | Filtered acceleration estimate |
| vel_o | output | STATE_W | Filtered velocity |
| valid_o | output | 1 | One-cycle pulse marking new outputs |

## Verification
A corrupted first integrator state does not show on `jerk_o` or `vel_o` right away. It shows on `accel_o` at the next update, and on `vel_o` in that same update. A corrupted second integrator state shows directly on `vel_o`, because the velocity output is that state. A missed or doubled state update therefore surfaces at the ports within one update. A wrong saturation bound surfaces only after a long ramp in one direction, so the bench drives both integrators into each rail and holds them there.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int DEF_ERR_W   = 16;
  localparam int DEF_COEF_W  = 16;
  localparam int DEF_FRAC_W  = 12;
  localparam int DEF_STATE_W = 24;
endpackage

// File: rtl/vlf_sat_add.sv
module vlf_sat_add #(
  parameter int W = 24
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] sum_o
);
  localparam logic signed [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide_sum;

  always_comb begin
    wide_sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    if (wide_sum[W] != wide_sum[W-1]) begin
      sum_o = wide_sum[W] ? NEG_LIM : POS_LIM;
    end else begin
      sum_o = wide_sum[W-1:0];
    end
  end
endmodule

// File: rtl/vlf_coef_mult.sv
module vlf_coef_mult #(
  parameter int ERR_W  = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 12,
  parameter int OUT_W  = 24
) (
  input  logic signed [ERR_W-1:0]  err_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [OUT_W-1:0]  term_o
);
  localparam int PROD_W = ERR_W + COEF_W;
  localparam int SH_W   = PROD_W - FRAC_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [SH_W-1:0]   shifted;

  assign prod    = PROD_W'(err_i) * PROD_W'(coef_i);
  assign shifted = SH_W'(prod >>> FRAC_W);

  generate
    if (SH_W < OUT_W) begin : g_extend
      assign term_o = {{(OUT_W-SH_W){shifted[SH_W-1]}}, shifted};
    end else if (SH_W == OUT_W) begin : g_pass
      assign term_o = shifted;
    end else begin : g_clip
      logic upper_same;
      assign upper_same = (&shifted[SH_W-1:OUT_W-1]) | ~(|shifted[SH_W-1:OUT_W-1]);
      assign term_o = upper_same ? shifted[OUT_W-1:0]
                    : (shifted[SH_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                       : {1'b0, {(OUT_W-1){1'b1}}});
    end
  endgenerate
endmodule

// File: rtl/vlf_integrator.sv
module vlf_integrator #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic signed [W-1:0] add_i,
  output logic signed [W-1:0] state_o,
  output logic signed [W-1:0] next_o
);
  logic signed [W-1:0] state_q;
  logic signed [W-1:0] state_d;
  logic signed [W-1:0] sum;

  vlf_sat_add #(.W(W)) i_add (
    .a_i   (state_q),
    .b_i   (add_i),
    .sum_o (sum)
  );

  always_comb begin
    state_d = state_q;
    if (en_i) begin
      state_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
  assign next_o  = sum;
endmodule

// File: rtl/vel_loop_filter.sv
module vel_loop_filter
  import vlf_pkg::*;
#(
  parameter int ERR_W   = DEF_ERR_W,
  parameter int COEF_W  = DEF_COEF_W,
  parameter int FRAC_W  = DEF_FRAC_W,
  parameter int STATE_W = DEF_STATE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_i,
  input  logic signed [ERR_W-1:0]   err_i,
  input  logic signed [COEF_W-1:0]  kj_i,
  input  logic signed [COEF_W-1:0]  ka_i,
  output logic signed [STATE_W-1:0] jerk_o,
  output logic signed [STATE_W-1:0] accel_o,
  output logic signed [STATE_W-1:0] vel_o,
  output logic                      valid_o
);
  localparam int NTERM = 2;

  logic signed [COEF_W-1:0]  coef  [NTERM];
  logic signed [STATE_W-1:0] term  [NTERM];
  logic signed [STATE_W-1:0] s1_q;
  logic signed [STATE_W-1:0] s1_unused_next;
  logic signed [STATE_W-1:0] s2_q;
  logic signed [STATE_W-1:0] s2_next;
  logic signed [STATE_W-1:0] accel_c;

  logic signed [STATE_W-1:0] jerk_q, jerk_d;
  logic signed [STATE_W-1:0] accel_q, accel_d;
  logic                      valid_q, valid_d;

  assign coef[0] = kj_i;
  assign coef[1] = ka_i;

  // term[0]: jerk term, term[1]: proportional part of acceleration
  generate
    for (genvar t = 0; t < NTERM; t++) begin : g_term
      vlf_coef_mult #(
        .ERR_W  (ERR_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W),
        .OUT_W  (STATE_W)
      ) i_mult (
        .err_i  (err_i),
        .coef_i (coef[t]),
        .term_o (term[t])
      );
    end
  endgenerate

  // first integrator accumulates the jerk term
  vlf_integrator #(.W(STATE_W)) i_int_jerk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (upd_i),
    .add_i   (term[0]),
    .state_o (s1_q),
    .next_o  (s1_unused_next)
  );

  vlf_sat_add #(.W(STATE_W)) i_accel_add (
    .a_i   (s1_q),
    .b_i   (term[1]),
    .sum_o (accel_c)
  );

  // second integrator accumulates the acceleration term
  vlf_integrator #(.W(STATE_W)) i_int_accel (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (upd_i),
    .add_i   (accel_c),
    .state_o (s2_q),
    .next_o  (s2_next)
  );

  always_comb begin
    jerk_d  = jerk_q;
    accel_d = accel_q;
    valid_d = upd_i;
    if (upd_i) begin
      jerk_d  = term[0];
      accel_d = accel_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jerk_q  <= '0;
      accel_q <= '0;
      valid_q <= 1'b0;
    end else begin
      jerk_q  <= jerk_d;
      accel_q <= accel_d;
      valid_q <= valid_d;
    end
  end

  assign jerk_o  = jerk_q;
  assign accel_o = accel_q;
  assign vel_o   = s2_q;
  assign valid_o = valid_q;

  logic unused_ok;
  assign unused_ok = ^{s1_unused_next, s2_next};
endmodule

// File: rtl/vlf_checker.sv
module vlf_checker #(
  parameter int STATE_W = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      upd_i,
  input logic signed [STATE_W-1:0] jerk_o,
  input logic signed [STATE_W-1:0] accel_o,
  input logic signed [STATE_W-1:0] vel_o,
  input logic                      valid_o
);
  // R6
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> valid_o);

  // R6
  valid_only_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> !valid_o);

  // R7
  vel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(vel_o));

  // R7
  accel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(accel_o) && $stable(jerk_o)));

  // R5
  vel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && accel_o > 0) |-> vel_o >= $past(vel_o));

  // R5
  vel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && accel_o < 0) |-> vel_o <= $past(vel_o));
endmodule

bind vel_loop_filter vlf_checker #(.STATE_W(STATE_W)) i_vlf_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .upd_i   (upd_i),
  .jerk_o  (jerk_o),
  .accel_o (accel_o),
  .vel_o   (vel_o),
  .valid_o (valid_o)
);

// File: tb/test_vel_loop_filter.sv
module test_vel_loop_filter;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 16;
  localparam int CW = 16;
  localparam int FW = 12;
  localparam int SW = 24;
  localparam longint PMAX = (64'sd1 <<< (SW-1)) - 1;
  localparam longint NMIN = -(64'sd1 <<< (SW-1));

  typedef struct {
    longint jerk;
    longint accel;
    longint vel;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic signed [EW-1:0] err = '0;
  logic signed [CW-1:0] kj = '0;
  logic signed [CW-1:0] ka = '0;
  logic signed [SW-1:0] jerk, accel, vel;
  logic valid;

  int checks = 0;
  int errors = 0;
  int n_valid = 0;
  int n_upd = 0;
  longint m_s1 = 0;
  longint m_s2 = 0;
  exp_t last_exp = '{0, 0, 0};
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vel_loop_filter #(.ERR_W(EW), .COEF_W(CW), .FRAC_W(FW), .STATE_W(SW)) i_vel_loop_filter (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .err_i(err), .kj_i(kj), .ka_i(ka),
    .jerk_o(jerk), .accel_o(accel), .vel_o(vel), .valid_o(valid)
  );

  function automatic longint sat(longint x);
    if (x > PMAX) return PMAX;
    if (x < NMIN) return NMIN;
    return x;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one update strobe, expected result pushed to the scoreboard
  task automatic drive_upd(int e, int cj, int ca);
    exp_t x;
    longint pj, pa;
    @(negedge clk);
    err = EW'(e); kj = CW'(ca == ca ? cj : 0); ka = CW'(ca);
    upd = 1'b1;
    n_upd++;
    pj = sat((longint'(e) * longint'(cj)) >>> FW);
    pa = (longint'(e) * longint'(ca)) >>> FW;
    x.jerk  = pj;
    x.accel = sat(m_s1 + pa);
    m_s1    = sat(m_s1 + pj);
    m_s2    = sat(m_s2 + x.accel);
    x.vel   = m_s2;
    q.push_back(x);
    last_exp = x;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      upd = 1'b0;
    end
  endtask

  // monitor: pops and compares each result when valid is seen
  always @(negedge clk) begin
    if (rst_n && valid) begin
      n_valid++;
      if (q.size() == 0) begin
        check("R6 unexpected valid", 1, 0);
      end else begin
        exp_t x;
        x = q.pop_front();
        check("R2 jerk", longint'(jerk), x.jerk);
        check("R3 R4 accel", longint'(accel), x.accel);
        check("R5 vel", longint'(vel), x.vel);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 jerk in reset", longint'(jerk), 0);
    check("R1 vel in reset", longint'(vel), 0);
    check("R1 valid in reset", longint'(valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check("R1 accel after reset", longint'(accel), 0);
    check("R1 valid after reset", longint'(valid), 0);

    // main function, several patterns
    drive_upd(1000, 2048, 8192);
    idle(1);
    drive_upd(-500, 2048, 8192);
    idle(3);
    drive_upd(-7, 1, 1);          // R2 floor rounding of negative products
    idle(1);
    drive_upd(32767, -300, 4096);
    idle(2);
    // back-to-back strobes (R6)
    drive_upd(1234, 100, 200);
    drive_upd(-4321, 777, -555);
    drive_upd(99, 4095, 4096);
    idle(2);
    check("R6 valid count", n_valid, n_upd);

    // R7: inputs move without strobe, outputs hold
    @(negedge clk);
    err = 16'sh7fff; kj = 16'sh7fff; ka = 16'sh8000;
    idle(4);
    check("R7 jerk held", longint'(jerk), last_exp.jerk);
    check("R7 accel held", longint'(accel), last_exp.accel);
    check("R7 vel held", longint'(vel), last_exp.vel);
    check("R7 no valid", longint'(valid), 0);

    // R8: ramp into the positive rail and stay there
    for (int i = 0; i < 60; i++) begin
      drive_upd(32767, 32767, 32767);
      idle(1);
    end
    idle(1);
    check("R8 vel at positive rail", longint'(vel), PMAX);
    check("R8 accel at positive rail", longint'(accel), PMAX);

    // R8: ramp into the negative rail
    for (int i = 0; i < 140; i++) begin
      drive_upd(-32768, 32767, 32767);
      idle(1);
    end
    idle(1);
    check("R8 vel at negative rail", longint'(vel), NMIN);
    check("R8 accel at negative rail", longint'(accel), NMIN);

    // R1: asynchronous reset mid-run clears the integrators
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 vel cleared", longint'(vel), 0);
    check("R1 accel cleared", longint'(accel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_s1 = 0;
    m_s2 = 0;
    idle(1);
    drive_upd(2000, 4096, 4096);
    idle(1);
    drive_upd(2000, 4096, 4096);
    idle(3);
    check("R6 final valid count", n_valid, n_upd);
    check("R6 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule